// File: doc/BRIEF.md
# Round-Robin Channel Merge FIFO

This block gathers time-stamp words from four independent sources and funnels them into a single store of 256 entries. Each source offers one word at a time with a valid/ready handshake. A rotating arbiter picks at most one source per clock. Priority moves to the neighbour of the source just served, so one busy source can take every cycle, and four busy sources each get one cycle in four. The arbiter adds the source number to each word, so the origin of a word is still known after the merge.

The read side is a first-word-fall-through port. The oldest word is always shown on `rd_data` while `empty` is low, and a one-cycle `rd_en` strobe removes it. A level flag rises once the number of stored words reaches a programmable threshold. A reader that sees the level flag can then take a block of that many words without checking `empty` between reads. A read while the store is empty is ignored.

Input back-pressure follows these rules:
- A source raises `in_valid` and holds it, with its data stable, until it sees `in_ready` in the same cycle.
- `in_ready` is formed from the current valid inputs. It is high for at most one source, and only in the cycle in which that source's word is taken.
- While the store is full, `in_ready` stays low for every source.

Top module: `chan_merge_fifo`

## Requirements
- R1: After reset, `empty` is 1 and the store holds no words. `load_level` is 1 only if `fill_thresh` is 0. `in_ready` stays 0 until a source raises valid.
- R2: At most one bit of `in_ready` is high in any cycle, so at most one word enters per clock.
- R3: Priority rotates. After a word from source i is taken, source (i+1) mod 4 has top priority. Sources with no valid word are skipped in ascending cyclic order. After reset, source 0 has top priority.
- R4: A source that is the only one with valid data is granted on every cycle while space is free.
- R5: Each stored word is `{source, data}`. Bits [9:8] hold the 2-bit source number and bits [7:0] hold the source's data. Words leave in the order they were accepted.
- R6: `empty` is active high. It falls at the first clock edge at which a word is written into an empty store, and it rises again when the last word is read.
- R7: `load_level` is active high. It is 1 exactly when the number of stored words is at least `fill_thresh`.
- R8: A `rd_en` while `empty` is 1 is ignored. The stored contents, the flags and the read order stay unchanged.
- R9: When 256 words are held, no source is granted, and the count never exceeds 256. The priority pointer keeps its value until a word is accepted again.
- R10: When a word is written and a word is read at the same edge, the stored word count does not change.
- R11: With all four sources valid all the time, the sources are served in cyclic order and each gets exactly one grant in every four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 4 | Per-source word valid |
| in_data | input | 32 | Per-source words, source k at bits [8k+7:8k] |
| in_ready | output | 4 | Per-source accept, one-hot or zero |
| fill_thresh | input | 9 | Level-flag threshold, 0 to 256 |
| rd_en | input | 1 | Read strobe, removes the head word |
| rd_data | output | 10 | Head word: {source, data} |
| empty | output | 1 | Store holds no words |
| load_level | output | 1 | Stored word count is at least `fill_thresh` |

## Verification
A grant appears combinationally in the cycle whose inputs cause it. A word accepted at a rising edge shows up in the store from that edge on. It can lower `empty` and change `load_level` after that single register stage, and the same holds for a read strobe taking effect. The bench drives every input on the falling edge and samples 1 ns later. At that point it compares `in_ready` with the grant its own arithmetic priority model predicts for the coming edge. It also compares `rd_data`, `empty` and `load_level` with the state its model holds after the previous edge, so each result is checked in the cycle in which it is due.

// File: rtl/cmf_pkg.sv
package cmf_pkg;
  // cyclic successor of an index within a ring of n positions
  function automatic int unsigned ring_next(input int unsigned v, input int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  // index k steps after base within a ring of n positions
  function automatic int unsigned ring_add(input int unsigned base, input int unsigned k,
                                           input int unsigned n);
    int unsigned s;
    s = base + k;
    return (s >= n) ? s - n : s;
  endfunction
endpackage

// File: rtl/cmf_arbiter.sv
module cmf_arbiter
  import cmf_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  input  logic              block,
  output logic [NUM_CH-1:0] grant,
  output logic [IDX_W-1:0]  grant_idx
);
  logic [IDX_W-1:0] prio;
  logic             found;

  always_comb begin
    grant     = '0;
    grant_idx = '0;
    found     = 1'b0;
    for (int k = 0; k < NUM_CH; k++) begin
      int unsigned c;
      c = ring_add(int'(prio), k, NUM_CH);
      if (!found && !block && req[c]) begin
        found     = 1'b1;
        grant[c]  = 1'b1;
        grant_idx = IDX_W'(c);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prio <= '0;
    else if (found) prio <= IDX_W'(ring_next(int'(grant_idx), NUM_CH));
  end

  assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_head_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!block && req[prio]) |-> grant[prio]);

  assert_prio_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |=> $stable(prio));
endmodule

// File: rtl/cmf_store.sv
module cmf_store #(
  parameter int WORD_W = 10,
  parameter int DEPTH  = 256,
  parameter int AW     = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_req,
  output logic [WORD_W-1:0] rd_word,
  output logic              empty,
  output logic              full,
  output logic [CNT_W-1:0]  count
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              wr_ok, rd_ok;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign wr_ok   = wr_en && !full;
  assign rd_ok   = rd_req && !empty;
  assign rd_word = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= wr_ptr + AW'(1);
      if (rd_ok) rd_ptr <= rd_ptr + AW'(1);
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  assert_empty_read_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && empty) |=> $stable(rd_ptr));

  assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && rd_ok) |=> $stable(count));

  assert_empty_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && empty) |=> !empty);
endmodule

// File: rtl/chan_merge_fifo.sv
module chan_merge_fifo #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int WORD_W = DATA_W + IDX_W,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        in_valid,
  input  logic [NUM_CH*DATA_W-1:0] in_data,
  output logic [NUM_CH-1:0]        in_ready,
  input  logic [CNT_W-1:0]         fill_thresh,
  input  logic                     rd_en,
  output logic [WORD_W-1:0]        rd_data,
  output logic                     empty,
  output logic                     load_level
);
  logic [DATA_W-1:0] chan_word [NUM_CH];
  logic [NUM_CH-1:0] grant;
  logic [IDX_W-1:0]  grant_idx;
  logic              full;
  logic [CNT_W-1:0]  count;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_split
    assign chan_word[g] = in_data[g*DATA_W +: DATA_W];
  end

  cmf_arbiter #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (in_valid),
    .block     (full),
    .grant     (grant),
    .grant_idx (grant_idx)
  );

  cmf_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (|grant),
    .wr_word ({grant_idx, chan_word[grant_idx]}),
    .rd_req  (rd_en),
    .rd_word (rd_data),
    .empty   (empty),
    .full    (full),
    .count   (count)
  );

  assign in_ready   = grant;
  assign load_level = (count >= fill_thresh);

  assert_no_grant_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (in_ready == '0));

  assert_ready_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~in_valid) == '0);
endmodule

// File: tb/sim_chan_merge_fifo.sv
module sim_chan_merge_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  in_valid = '0;
  logic [31:0] in_data = '0;
  logic [3:0]  in_ready;
  logic [8:0]  fill_thresh = '0;
  logic        rd_en = 1'b0;
  logic [9:0]  rd_data;
  logic        empty;
  logic        load_level;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // bench model
  logic [9:0] mq [512];
  int mhead = 0, mtail = 0, mcount = 0, mprio = 0;
  logic [7:0] seq [4];
  int gcnt [4];
  string gtag = "R3";

  always #5 clk = ~clk;

  chan_merge_fifo u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .fill_thresh(fill_thresh), .rd_en(rd_en),
    .rd_data(rd_data), .empty(empty), .load_level(load_level)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input logic [3:0] vmask, input logic rd);
    logic [3:0] eg;
    int gi;
    @(negedge clk);
    in_valid = vmask;
    for (int c = 0; c < 4; c++) in_data[c*8 +: 8] = seq[c];
    rd_en = rd;
    #1;
    chk(empty == (mcount == 0), "R6", 64'(empty), 64'(mcount == 0));
    chk(load_level == (mcount >= int'(fill_thresh)), "R7", 64'(load_level),
        64'(mcount >= int'(fill_thresh)));
    eg = '0; gi = 0;
    if (mcount < 256)
      for (int k = 0; k < 4; k++) begin
        int c;
        c = (mprio + k) % 4;
        if (eg == '0 && vmask[c]) begin eg[c] = 1'b1; gi = c; end
      end
    chk(in_ready == eg, gtag, 64'(in_ready), 64'(eg));
    for (int c = 0; c < 4; c++) if (in_ready[c]) gcnt[c]++;
    if (rd && mcount > 0) begin
      chk(rd_data == mq[mhead], "R5", 64'(rd_data), 64'(mq[mhead]));
      mhead = (mhead + 1) % 512;
      mcount--;
    end
    if (eg != '0) begin
      mq[mtail] = {gi[1:0], seq[gi]};
      mtail = (mtail + 1) % 512;
      mcount++;
      seq[gi] = seq[gi] + 8'd1;
      mprio = (gi + 1) % 4;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin seq[c] = 8'(c * 64); gcnt[c] = 0; end
    fill_thresh = 9'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(empty == 1'b1, "R1", 64'(empty), 64'd1);
    chk(in_ready == 4'd0, "R1", 64'(in_ready), 64'd0);
    chk(load_level == 1'b0, "R1", 64'(load_level), 64'd0);
    fill_thresh = 9'd0; #1;
    chk(load_level == 1'b1, "R1", 64'(load_level), 64'd1);
    fill_thresh = 9'd4;

    // R4 single active source every cycle
    gtag = "R4";
    for (int i = 0; i < 10; i++) step(4'b0100, 1'b0);
    chk(gcnt[2] == 10, "R4", 64'(gcnt[2]), 64'd10);

    // R11 all four busy: one in four each
    gtag = "R11";
    for (int c = 0; c < 4; c++) gcnt[c] = 0;
    for (int i = 0; i < 16; i++) step(4'b1111, 1'b0);
    for (int c = 0; c < 4; c++) chk(gcnt[c] == 4, "R11", 64'(gcnt[c]), 64'd4);

    // R3 sweep over all valid masks, with concurrent reads (R10 paths)
    gtag = "R3";
    for (int m = 0; m < 16; m++)
      for (int r = 0; r < 3; r++) step(4'(m), r[0]);

    // R5 / R6 drain everything
    while (mcount > 0) step(4'b0000, 1'b1);
    step(4'b0000, 1'b0);
    chk(empty == 1'b1, "R6", 64'(empty), 64'd1);

    // R8 reads while empty are ignored
    for (int i = 0; i < 3; i++) step(4'b0000, 1'b1);
    chk(empty == 1'b1, "R8", 64'(empty), 64'd1);
    step(4'b0010, 1'b0);
    step(4'b0000, 1'b0);
    chk(rd_data == mq[mhead], "R8", 64'(rd_data), 64'(mq[mhead]));
    step(4'b0000, 1'b1);
    step(4'b0000, 1'b0);
    chk(empty == 1'b1, "R8", 64'(empty), 64'd1);

    // R7 threshold sweep while filling
    for (int t = 1; t <= 9; t += 4) begin
      fill_thresh = 9'(t);
      for (int i = 0; i < 12; i++) step(4'b1001, 1'b0);
      while (mcount > 0) step(4'b0000, 1'b1);
    end

    // R10 simultaneous write and read at a fixed count
    for (int i = 0; i < 5; i++) step(4'b0001, 1'b0);
    fill_thresh = 9'd5;
    step(4'b0110, 1'b1);
    step(4'b0000, 1'b0);
    chk(load_level == 1'b1, "R10", 64'(load_level), 64'd1);
    fill_thresh = 9'd6; #1;
    chk(load_level == 1'b0, "R10", 64'(load_level), 64'd0);

    // R9 fill to 256 and verify no grants, pointer held
    gtag = "R9";
    fill_thresh = 9'd256;
    while (mcount < 256) step(4'b1111, 1'b0);
    for (int i = 0; i < 4; i++) step(4'b1111, 1'b0);
    chk(in_ready == 4'd0, "R9", 64'(in_ready), 64'd0);
    chk(load_level == 1'b1, "R9", 64'(load_level), 64'd1);
    step(4'b1111, 1'b1);
    step(4'b1111, 1'b0);
    gtag = "R5";
    while (mcount > 0) step(4'b0000, 1'b1);
    step(4'b0000, 1'b0);
    chk(empty == 1'b1, "R6", 64'(empty), 64'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule